// File: doc/BRIEF.md
# Input Dynamic Range Extension Controller

This block sits behind one ADC channel and enlarges the input range that can be used without changing the overall path gain. It looks at each incoming signed PCM sample. When the signal gets loud, it raises an analog attenuation code for the microphone amplifier by one 6 dB step. Each such step is cancelled by a one-bit left shift of the digitised samples, saturated to the sample width. The net gain from microphone to filter output therefore stays constant, and the analog front end gains headroom.

Several settings control it. A trigger level sets the loudness that counts as loud, and a maximum attenuation caps the number of steps. An optional hold timeout releases one step after a long quiet stretch. An optional anti-clip path reacts at once to near-full-scale samples. The block is cleared and held transparent whenever it is switched off, and also whenever a level-control function is active on the same path, because the two may not run together. One valid sample is accepted per strobe, and the compensated sample comes out one clock later.

Top module: `dre_ctrl`

## Requirements
- R1: After synchronous reset, `att_code` is 0, `att_active` is 0 and `out_valid` is 0.
- R2: Every accepted sample yields `out_valid` high on the next clock, with `out_sample` equal to the input shifted left by the attenuation in force when the sample arrived, saturated to the range -32768..32767 (for the default 16-bit width). Without `in_valid`, `out_valid` is low.
- R3: Trigger code k (0..15) sets a threshold of 2^(15-(15-k)) = 32768/2^(15-k), which runs from -90 dBFS at k=0 to 0 dBFS at k=15. A sample counts as loud only when its magnitude is strictly greater than this threshold.
- R4: A loud sample raises attenuation by exactly one step. After any change of attenuation, at least four further accepted samples must pass before a loud sample may raise it again.
- R5: Attenuation never exceeds the maximum-attenuation code. Codes above 6 act as 6. If the maximum is lowered below the present attenuation, the next accepted sample brings the attenuation down to the new maximum.
- R6: When anti-clip is enabled, a sample whose magnitude is at least 7/8 of full scale (28672) raises attenuation by one step at once, ignoring the four-sample spacing of R4. A magnitude of 28671 does not qualify.
- R7: With the timeout enabled, 4800 consecutive quiet accepted samples (0.1 s at 48 kHz) lower attenuation by one step. With the timeout disabled, attenuation is never released.
- R8: Attenuation changes only on a clock that accepts a sample, or on a clock where the block is disabled. It never rises by more than one step at a time.
- R9: When `cfg_enable` is low or `alc_active` is high, `att_code` becomes 0 on the next clock. Accepted samples then pass through unchanged, and loud samples raise nothing.
- R10: `att_active` is high exactly when `att_code` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Signed PCM sample from the ADC |
| cfg_enable | input | 1 | Range extension enable |
| alc_active | input | 1 | Level control active on this path (forces disable) |
| cfg_trigger | input | 4 | Trigger level code, 6 dB per step |
| cfg_att_max | input | 3 | Maximum attenuation in 6 dB steps |
| cfg_timeout_en | input | 1 | Enables release after the quiet timeout |
| cfg_anticlip_en | input | 1 | Enables the anti-clip fast path |
| out_valid | output | 1 | Compensated sample strobe |
| out_sample | output | 16 | Digitally compensated sample |
| att_code | output | 3 | Analog attenuation code in 6 dB steps |
| att_active | output | 1 | High while any attenuation is applied |

## Verification
A wrong attenuation register shows up at the ports in two ways. The attenuation code is wrong on the clock after the sample that should have moved it, and the very next compensated sample is off by a factor of two, which makes a gain mismatch visible within one sample. Faults in the spacing or hold counters only become visible at the first loud or quiet sample that falls on the wrong count. The bench therefore places samples just before and just after each count boundary: the fifth loud sample, the 4799th and 4800th quiet samples, and magnitudes of threshold and threshold plus one.

// File: rtl/dre_pkg.sv
package dre_pkg;
  // Per-sample level classification passed from the detector to the stepper.
  typedef struct packed {
    logic loud;  // magnitude above the programmed trigger
    logic clip;  // near full scale while anti-clip is enabled
  } lvl_t;
endpackage

// File: rtl/dre_level_det.sv
module dre_level_det
  import dre_pkg::*;
#(
  parameter int DW     = 16,
  parameter int TRIG_W = 4
) (
  input  logic [DW-1:0]     sample,
  input  logic [TRIG_W-1:0] trig,
  input  logic              anticlip_en,
  output lvl_t              lvl
);
  localparam int TRIG_TOP = (1 << TRIG_W) - 1;
  localparam logic [DW:0] FULL = (DW+1)'(1) << (DW-1);
  localparam logic [DW:0] CLIP_THR = FULL - (FULL >> 3);

  logic signed [DW:0] sx;
  logic [DW:0] mag;
  logic [DW:0] thr;

  always_comb begin
    sx  = {sample[DW-1], sample};
    mag = sx[DW] ? unsigned'(-sx) : unsigned'(sx);
    thr = FULL >> (TRIG_TOP - int'(trig));
    lvl.loud = (mag > thr);
    lvl.clip = anticlip_en && (mag >= CLIP_THR);
  end
endmodule

// File: rtl/dre_gain_step.sv
module dre_gain_step
  import dre_pkg::*;
#(
  parameter int ATT_W           = 3,
  parameter int MAX_STEPS       = 6,
  parameter int ATTACK_HOLD     = 4,
  parameter int TIMEOUT_SAMPLES = 4800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             in_valid,
  input  lvl_t             lvl,
  input  logic [ATT_W-1:0] att_max_cfg,
  input  logic             timeout_en,
  output logic [ATT_W-1:0] att_q
);
  localparam int GW = $clog2(ATTACK_HOLD + 1);
  localparam int HW = $clog2(TIMEOUT_SAMPLES);
  localparam logic [GW-1:0]    GAP_FULL = GW'(ATTACK_HOLD);
  localparam logic [HW-1:0]    HOLD_END = HW'(TIMEOUT_SAMPLES - 1);
  localparam logic [ATT_W-1:0] STEP_CAP = ATT_W'(MAX_STEPS);

  logic [GW-1:0]    gap_q;
  logic [HW-1:0]    hold_q;
  logic [ATT_W-1:0] lim;
  logic             may_rise;

  always_comb begin
    lim      = (att_max_cfg > STEP_CAP) ? STEP_CAP : att_max_cfg;
    may_rise = (att_q < lim) && (lvl.clip || (lvl.loud && gap_q == GAP_FULL));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      att_q  <= '0;
      gap_q  <= GAP_FULL;
      hold_q <= '0;
    end else if (in_valid) begin
      if (att_q > lim) begin
        att_q  <= lim;
        gap_q  <= '0;
        hold_q <= '0;
      end else if (lvl.loud || lvl.clip) begin
        hold_q <= '0;
        if (may_rise) begin
          att_q <= att_q + 1'b1;
          gap_q <= '0;
        end else if (gap_q != GAP_FULL) begin
          gap_q <= gap_q + 1'b1;
        end
      end else begin
        if (gap_q != GAP_FULL) gap_q <= gap_q + 1'b1;
        if (!timeout_en) begin
          hold_q <= '0;
        end else if (hold_q == HOLD_END) begin
          hold_q <= '0;
          if (att_q != '0) begin
            att_q <= att_q - 1'b1;
            gap_q <= '0;
          end
        end else begin
          hold_q <= hold_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dre_gain_apply.sv
module dre_gain_apply #(
  parameter int DW    = 16,
  parameter int ATT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_sample,
  input  logic [ATT_W-1:0] shift,
  output logic             out_valid,
  output logic [DW-1:0]    out_sample
);
  localparam int WW = DW + (1 << ATT_W) - 1;
  localparam logic signed [WW-1:0] PMAX = {{(WW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [WW-1:0] NMIN = {{(WW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [WW-1:0] wide;
  logic [DW-1:0]        sat;

  always_comb begin
    wide = signed'({{(WW-DW){in_sample[DW-1]}}, in_sample}) <<< shift;
    if (wide > PMAX)      sat = PMAX[DW-1:0];
    else if (wide < NMIN) sat = NMIN[DW-1:0];
    else                  sat = wide[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sample <= sat;
    end
  end
endmodule

// File: rtl/dre_ctrl.sv
module dre_ctrl
  import dre_pkg::*;
#(
  parameter int DW              = 16,
  parameter int TRIG_W          = 4,
  parameter int ATT_W           = 3,
  parameter int MAX_STEPS       = 6,
  parameter int ATTACK_HOLD     = 4,
  parameter int TIMEOUT_SAMPLES = 4800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_sample,
  input  logic              cfg_enable,
  input  logic              alc_active,
  input  logic [TRIG_W-1:0] cfg_trigger,
  input  logic [ATT_W-1:0]  cfg_att_max,
  input  logic              cfg_timeout_en,
  input  logic              cfg_anticlip_en,
  output logic              out_valid,
  output logic [DW-1:0]     out_sample,
  output logic [ATT_W-1:0]  att_code,
  output logic              att_active
);
  lvl_t             lvl;
  logic             en;
  logic [ATT_W-1:0] att_q;
  logic [ATT_W-1:0] shift;

  assign en    = cfg_enable && !alc_active;
  assign shift = en ? att_q : '0;

  dre_level_det #(.DW(DW), .TRIG_W(TRIG_W)) u_det (
    .sample      (in_sample),
    .trig        (cfg_trigger),
    .anticlip_en (cfg_anticlip_en),
    .lvl         (lvl)
  );

  dre_gain_step #(
    .ATT_W(ATT_W), .MAX_STEPS(MAX_STEPS),
    .ATTACK_HOLD(ATTACK_HOLD), .TIMEOUT_SAMPLES(TIMEOUT_SAMPLES)
  ) u_step (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .in_valid    (in_valid),
    .lvl         (lvl),
    .att_max_cfg (cfg_att_max),
    .timeout_en  (cfg_timeout_en),
    .att_q       (att_q)
  );

  dre_gain_apply #(.DW(DW), .ATT_W(ATT_W)) u_apply (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .shift      (shift),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  assign att_code   = att_q;
  assign att_active = (att_q != '0);
endmodule

// File: rtl/dre_ctrl_chk.sv
module dre_ctrl_chk #(
  parameter int DW    = 16,
  parameter int ATT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [DW-1:0]    in_sample,
  input logic             cfg_enable,
  input logic             alc_active,
  input logic [ATT_W-1:0] cfg_att_max,
  input logic             out_valid,
  input logic [DW-1:0]    out_sample,
  input logic [ATT_W-1:0] att_code
);
  assert_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_cap_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> att_code <= $past(cfg_att_max));
  assert_change_on_sample_R8: assert property (@(posedge clk) disable iff (rst)
    (att_code != $past(att_code)) |-> ($past(in_valid) || !$past(cfg_enable) || $past(alc_active)));
  assert_single_step_R8: assert property (@(posedge clk) disable iff (rst)
    (att_code > $past(att_code)) |-> (int'(att_code) == int'($past(att_code)) + 1));
  assert_disable_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_enable || alc_active) |=> att_code == '0);
  assert_passthru_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (!cfg_enable || alc_active)) |=> out_sample == $past(in_sample));
endmodule

bind dre_ctrl dre_ctrl_chk #(.DW(DW), .ATT_W(ATT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_sample   (in_sample),
  .cfg_enable  (cfg_enable),
  .alc_active  (alc_active),
  .cfg_att_max (cfg_att_max),
  .out_valid   (out_valid),
  .out_sample  (out_sample),
  .att_code    (att_code)
);

// File: tb/dre_ctrl_bench.sv
module dre_ctrl_bench;
  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic signed [15:0] in_sample;
  logic              cfg_enable, alc_active, cfg_timeout_en, cfg_anticlip_en;
  logic [3:0]        cfg_trigger;
  logic [2:0]        cfg_att_max;
  logic              out_valid;
  logic [15:0]       out_sample;
  logic [2:0]        att_code;
  logic              att_active;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dre_ctrl u_dre_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_enable(cfg_enable), .alc_active(alc_active), .cfg_trigger(cfg_trigger),
    .cfg_att_max(cfg_att_max), .cfg_timeout_en(cfg_timeout_en),
    .cfg_anticlip_en(cfg_anticlip_en), .out_valid(out_valid),
    .out_sample(out_sample), .att_code(att_code), .att_active(att_active)
  );

  typedef struct packed {
    logic signed [15:0] smp;
    logic signed [15:0] exp_out;
    logic [2:0]         exp_att;
  } vec_t;

  // Trigger code 9 -> threshold 512, maximum 6, timeout and anti-clip off.
  localparam vec_t VECS [16] = '{
    '{16'sd100,    16'sd100,    3'd0},
    '{-16'sd300,   -16'sd300,   3'd0},
    '{16'sd1000,   16'sd1000,   3'd1},
    '{16'sd1000,   16'sd2000,   3'd1},
    '{-16'sd1000,  -16'sd2000,  3'd1},
    '{16'sd600,    16'sd1200,   3'd1},
    '{16'sd513,    16'sd1026,   3'd1},
    '{16'sd513,    16'sd1026,   3'd2},
    '{16'sd20000,  16'sd32767,  3'd2},
    '{-16'sd20000, -16'sd32768, 3'd2},
    '{-16'sd512,   -16'sd2048,  3'd2},
    '{16'sd512,    16'sd2048,   3'd2},
    '{-16'sd513,   -16'sd2052,  3'd3},
    '{16'sd4095,   16'sd32760,  3'd3},
    '{16'sd4096,   16'sd32767,  3'd3},
    '{-16'sd4096,  -16'sd32768, 3'd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic signed [15:0] s);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = s;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_sample = '0;
    cfg_enable = 1'b1; alc_active = 1'b0; cfg_trigger = 4'd9;
    cfg_att_max = 3'd6; cfg_timeout_en = 1'b0; cfg_anticlip_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 att_code", int'(att_code), 0);
    chk("R1 att_active", int'(att_active), 0);
    chk("R1 out_valid", int'(out_valid), 0);

    // Table walk: compensation (R2), threshold (R3), attack spacing (R4).
    for (int i = 0; i < 16; i++) begin
      send(VECS[i].smp);
      chk($sformatf("R2 out_sample vec %0d", i), int'(signed'(out_sample)), int'(VECS[i].exp_out));
      chk($sformatf("R4 att vec %0d", i), int'(att_code), int'(VECS[i].exp_att));
      chk($sformatf("R10 active vec %0d", i), int'(att_active), int'(VECS[i].exp_att != 0));
    end
    @(negedge clk);
    chk("R2 out_valid idle", int'(out_valid), 0);

    // R5: lowering the cap clamps on the next sample, loud then holds.
    cfg_att_max = 3'd2;
    send(16'sd0);
    chk("R5 clamp", int'(att_code), 2);
    send(16'sd1000);
    chk("R5 at cap", int'(att_code), 2);

    // R6: anti-clip boundary and fast rise.
    cfg_att_max = 3'd6; cfg_anticlip_en = 1'b1;
    send(16'sd28671);
    chk("R6 below clip", int'(att_code), 2);
    send(16'sd28672);
    chk("R6 clip rise", int'(att_code), 3);
    send(-16'sd30000);
    chk("R6 clip rise again", int'(att_code), 4);
    chk("R2 saturate", int'(signed'(out_sample)), -32768);

    // R7: no release while the timeout is off, then release at 4800.
    cfg_anticlip_en = 1'b0;
    for (int i = 0; i < 5000; i++) send(16'sd0);
    chk("R7 no release", int'(att_code), 4);
    cfg_timeout_en = 1'b1;
    for (int i = 0; i < 4799; i++) send(16'sd10);
    chk("R7 before timeout", int'(att_code), 4);
    send(16'sd10);
    chk("R7 timeout release", int'(att_code), 3);
    cfg_timeout_en = 1'b0;

    // R9 and R8: disable clears without a sample, samples pass through.
    @(negedge clk);
    cfg_enable = 1'b0;
    @(negedge clk);
    chk("R9 disable clear", int'(att_code), 0);
    send(16'sd20000);
    chk("R9 pass through", int'(signed'(out_sample)), 20000);
    chk("R9 no rise", int'(att_code), 0);
    cfg_enable = 1'b1; alc_active = 1'b1;
    send(-16'sd20000);
    chk("R9 alc pass through", int'(signed'(out_sample)), -20000);
    chk("R9 alc no rise", int'(att_code), 0);
    alc_active = 1'b0;

    // R3: trigger extremes.
    cfg_trigger = 4'd15;
    send(-16'sd32768);
    chk("R3 top code quiet", int'(att_code), 0);
    cfg_trigger = 4'd0;
    send(16'sd1);
    chk("R3 bottom code quiet", int'(att_code), 0);
    send(16'sd2);
    chk("R3 bottom code loud", int'(att_code), 1);
    chk("R8 single step", int'(att_code), 1);

    // R5: cap of zero keeps the path transparent.
    cfg_att_max = 3'd0;
    send(16'sd300);
    chk("R5 cap zero", int'(att_code), 0);
    send(16'sd300);
    chk("R5 cap zero passthru", int'(signed'(out_sample)), 300);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule